// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a memory-mapped watchdog. A counter advances by one on each pulse of a slow tick enable. When a tick arrives while the watchdog is enabled and the counter has already reached the programmed timeout, the block raises a one-cycle reset request and starts counting again from zero. Software keeps the system alive by writing a refresh key to the counter address before that happens.

Configuration is guarded. The control and timeout registers accept writes only during an unlock window. Software opens the window by writing an unlock key to the counter address. The window closes when the control register is written, or after a fixed number of bus cycles with no configuration write. Keys are either single 32-bit words or pairs of 16-bit halves written one after the other; a control bit picks the form. If the update-permit bit is written as 0, the registers stay locked until reset.

The clock-select field and the two low-power enable bits are stored and read back but have no effect on behaviour.

Top module: `wdog_keyed`

## Requirements
- R1: Out of reset, control reads 0x0000_08A0 (unlocked bit 11 = 1, enable bit 7 = 1, update-permit bit 5 = 1, 16-bit key form), timeout reads 0xFFFF, counter reads 0 and `wdogRst` is low. Word address 0 is control, 1 is counter, 2 is timeout.
- R2: While enable (control bit 7) is 1, each `tickEn` pulse increments the counter by one. While enable is 0, the counter holds its value.
- R3: A tick that arrives while enabled and while counter >= timeout sets `wdogRst` high for exactly the following cycle and clears the counter. With timeout K, counting from 0, the reset request follows tick K+1.
- R4: With control bit 13 = 1, writing 0xB480A602 to the counter address clears the counter if enable is 1. The same key has no effect while enable is 0.
- R5: With control bit 13 = 0, writing 0xA602 and then 0xB480 as two consecutive counter-address writes clears the counter. The reversed order, or a pair broken by another counter-address write, has no effect.
- R6: An unlock key sets control bit 11 and clears bit 10. The unlock key is 0xD928C520 as one word when bit 13 = 1, or 0xC520 followed by 0xD928 when bit 13 = 0.
- R7: While unlocked, a control write stores bits 13, 9:8, 7, 5, 1 and 0, clears bit 11 and sets bit 10. A timeout write while unlocked stores the value and sets bit 10.
- R8: Writes to control or timeout while locked leave both registers unchanged.
- R9: The unlock window closes 255 bus cycles after the unlock key or after the last timeout write, whichever came later.
- R10: After a control write with bit 5 = 0, unlock keys are ignored until reset.
- R11: A counter-address write that matches no key leaves the counter and the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow count tick, one cycle per tick |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | 2 | Word address (0 control, 1 counter, 2 timeout) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| wdogRst | output | 1 | One-cycle reset request on timeout |

## Verification
The embedded assertions check the following on every cycle:
- the counter holds when disabled and steps by exactly one on an enabled tick below the limit;
- a reset request always coincides with a cleared counter and never appears without an enabled tick;
- locked control writes change nothing;
- an accepted control write ends the window and raises the done flag;
- an expired window and the permanent lock keep the block locked.

The bench scenarios cover what depends on sequences of bus writes:
- the position of the reset request across a sweep of timeout values;
- the order and interruption of 16-bit key halves;
- the exact length of the unlock window and its restart on a timeout write;
- refresh keys that have no effect while disabled.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [31:0] KEY_REF32 = 32'hB480_A602;
  localparam logic [31:0] KEY_UNL32 = 32'hD928_C520;
  localparam logic [15:0] KEY_REF_LO = 16'hA602;
  localparam logic [15:0] KEY_REF_HI = 16'hB480;
  localparam logic [15:0] KEY_UNL_LO = 16'hC520;
  localparam logic [15:0] KEY_UNL_HI = 16'hD928;

  localparam int BIT_CMD32 = 13;
  localparam int BIT_UNLK  = 11;
  localparam int BIT_DONE  = 10;
  localparam int BIT_EN    = 7;
  localparam int BIT_UPD   = 5;

  localparam logic [31:0] CTRL_STORE_MASK = 32'h0000_23A3;
  localparam logic [31:0] CTRL_RESET      = 32'h0000_00A0;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_CNT   = 2'd1,
    REG_TOVAL = 2'd2,
    REG_NONE  = 2'd3
  } regSel_t;

  typedef struct packed {
    logic clrCnt;
    logic loadTo;
  } dpStrobe_t;
endpackage

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
  import wdk_pkg::*;
#(
  parameter int WIN_CYC = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output dpStrobe_t   strobe,
  output logic        enable,
  output logic [31:0] ctrlRead
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [31:0]      ctrlReg;
  logic             unlocked;
  logic             cfgDone;
  logic             pendRef;
  logic             pendUnl;
  logic [WIN_W-1:0] win;

  logic wrCtrl, wrCnt, wrTo;
  logic cmd32;
  logic keyRefresh, keyUnlock;

  assign wrCtrl = wrEn && (addr == REG_CTRL);
  assign wrCnt  = wrEn && (addr == REG_CNT);
  assign wrTo   = wrEn && (addr == REG_TOVAL);
  assign cmd32  = ctrlReg[BIT_CMD32];
  assign enable = ctrlReg[BIT_EN];

  always_comb begin
    if (cmd32) begin
      keyRefresh = wrCnt && (wdata == KEY_REF32);
      keyUnlock  = wrCnt && (wdata == KEY_UNL32);
    end else begin
      keyRefresh = wrCnt && pendRef && (wdata == {16'h0, KEY_REF_HI});
      keyUnlock  = wrCnt && pendUnl && (wdata == {16'h0, KEY_UNL_HI});
    end
  end

  assign strobe.clrCnt = keyRefresh && enable;
  assign strobe.loadTo = wrTo && unlocked;

  always_comb begin
    ctrlRead = ctrlReg;
    ctrlRead[BIT_UNLK] = unlocked;
    ctrlRead[BIT_DONE] = cfgDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      unlocked <= 1'b1;
      cfgDone  <= 1'b0;
      pendRef  <= 1'b0;
      pendUnl  <= 1'b0;
      win      <= '0;
    end else begin
      if (wrCnt) begin
        pendRef <= !cmd32 && (wdata == {16'h0, KEY_REF_LO});
        pendUnl <= !cmd32 && (wdata == {16'h0, KEY_UNL_LO});
      end
      if (unlocked) begin
        win <= win + 1'b1;
        if (win == WIN_LAST) unlocked <= 1'b0;
      end
      if (wrTo && unlocked) begin
        win      <= '0;
        unlocked <= 1'b1;
        cfgDone  <= 1'b1;
      end
      if (wrCtrl && unlocked) begin
        ctrlReg  <= wdata & CTRL_STORE_MASK;
        unlocked <= 1'b0;
        cfgDone  <= 1'b1;
        pendRef  <= 1'b0;
        pendUnl  <= 1'b0;
      end
      if (keyUnlock && ctrlReg[BIT_UPD]) begin
        unlocked <= 1'b1;
        win      <= '0;
        cfgDone  <= 1'b0;
      end
    end
  end

  // R8: locked control writes are dropped
  a_r8_locked_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !unlocked) |=> $stable(ctrlReg));
  // R7: accepted control write closes the window and flags done
  a_r7_ctrl_accept: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && unlocked) |=> (cfgDone && !unlocked));
  // R10: permanent lock once update-permit is cleared
  a_r10_perm_lock: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[BIT_UPD] && !unlocked) |=> !unlocked);
  // R9: window expiry relocks
  a_r9_window_close: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && win == WIN_LAST && !wrTo && !keyUnlock) |=> !unlocked);
endmodule

// File: rtl/wdk_dp.sv
module wdk_dp
  import wdk_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter logic [31:0] TO_RESET = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             enable,
  input  dpStrobe_t        strobe,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] toval,
  output logic             bite
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      toval <= TO_RESET[CNT_W-1:0];
      bite  <= 1'b0;
    end else begin
      bite <= 1'b0;
      if (strobe.loadTo) toval <= wdata[CNT_W-1:0];
      if (strobe.clrCnt) begin
        cnt <= '0;
      end else if (enable && tickEn) begin
        if (cnt >= toval) begin
          cnt  <= '0;
          bite <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: a reset request always coincides with a cleared counter
  a_r3_bite_clears: assert property (@(posedge clk) disable iff (!rstN)
    bite |-> (cnt == '0));
  // R3: no reset request without an enabled tick
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && tickEn) |=> !bite);
  // R2: counter holds while disabled
  a_r2_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !strobe.clrCnt) |=> $stable(cnt));
  // R2: single step below the limit
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tickEn && !strobe.clrCnt && cnt < toval) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          WIN_CYC  = 255,
  parameter logic [31:0] TO_RESET = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        wdogRst
);
  dpStrobe_t        strobe;
  logic             enable;
  logic [31:0]      ctrlRead;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] toval;

  wdk_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wdata(busWdata),
    .strobe(strobe), .enable(enable), .ctrlRead(ctrlRead)
  );

  wdk_dp #(.CNT_W(CNT_W), .TO_RESET(TO_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .enable(enable), .strobe(strobe),
    .wdata(busWdata), .cnt(cnt), .toval(toval), .bite(wdogRst)
  );

  always_comb begin
    case (busAddr)
      REG_CTRL:  busRdata = ctrlRead;
      REG_CNT:   busRdata = 32'(cnt);
      REG_TOVAL: busRdata = 32'(toval);
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        wdogRst;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wdogRst(wdogRst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic tick(output logic r);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    r = wdogRst;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic r;
    doReset();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h08A0);
    rd(2'd2, v); chk("R1 timeout", v, 32'hFFFF);
    rd(2'd1, v); chk("R1 counter", v, 0);
    chk("R1 wdogRst", {31'b0, wdogRst}, 0);

    // R7 timeout then control write while unlocked
    wr(2'd2, 5);
    rd(2'd2, v); chk("R7 timeout stored", v, 5);
    rd(2'd0, v); chk("R7 done after timeout write", v[10], 1);
    wr(2'd0, 32'h20A0);
    rd(2'd0, v); chk("R7 ctrl stored, locked, done", v, 32'h24A0);

    // R8 locked writes ignored
    wr(2'd2, 9);
    rd(2'd2, v); chk("R8 locked timeout", v, 5);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R8 locked ctrl", v, 32'h24A0);

    // R2 counting, R11 wrong key, R4 32-bit refresh
    for (int i = 0; i < 3; i++) tick(r);
    rd(2'd1, v); chk("R2 count after 3 ticks", v, 3);
    wr(2'd1, 32'hB480A603);
    rd(2'd1, v); chk("R11 wrong key counter", v, 3);
    rd(2'd0, v); chk("R11 wrong key lock state", v[11], 0);
    wr(2'd1, 32'hB480A602);
    rd(2'd1, v); chk("R4 refresh32 clears", v, 0);

    // R3 sweep of timeout values, R6 32-bit unlock
    for (int k = 0; k <= 6; k++) begin
      wr(2'd1, 32'hD928C520);
      rd(2'd0, v); chk("R6 unlock32 sets bit11 clears bit10", {30'b0, v[11], v[10]}, 32'h2);
      wr(2'd2, k);
      wr(2'd0, 32'h20A0);
      wr(2'd1, 32'hB480A602);
      for (int t = 1; t <= k + 1; t++) begin
        tick(r);
        chk($sformatf("R3 bite position k=%0d t=%0d", k, t), {31'b0, r}, {31'b0, (t == k + 1)});
      end
      rd(2'd1, v); chk("R3 counter cleared on bite", v, 0);
      chk("R3 one-cycle pulse", {31'b0, wdogRst}, 0);
    end

    // R5 16-bit refresh
    wr(2'd1, 32'hD928C520);
    wr(2'd0, 32'h00A0);
    for (int i = 0; i < 3; i++) tick(r);
    wr(2'd1, 32'hA602); wr(2'd1, 32'hB480);
    rd(2'd1, v); chk("R5 refresh16 pair clears", v, 0);
    tick(r); tick(r);
    wr(2'd1, 32'hB480); wr(2'd1, 32'hA602);
    rd(2'd1, v); chk("R5 reversed pair ignored", v, 2);
    wr(2'd1, 32'hA602); wr(2'd1, 32'h1234); wr(2'd1, 32'hB480);
    rd(2'd1, v); chk("R5 broken pair ignored", v, 2);

    // R6 16-bit unlock, R9 window length
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    rd(2'd0, v); chk("R6 unlock16 sets bit11", v[11], 1);
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    idle(249);
    rd(2'd0, v); chk("R9 open before 255 cycles", v[11], 1);
    idle(10);
    rd(2'd0, v); chk("R9 closed after 255 cycles", v[11], 0);
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    idle(200);
    wr(2'd2, 100);
    idle(200);
    rd(2'd0, v); chk("R9 timeout write restarts window", v[11], 1);
    idle(60);
    rd(2'd0, v); chk("R9 restarted window closes", v[11], 0);

    // R2 disabled hold, R4 refresh ignored when disabled
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    wr(2'd0, 32'h0020);
    for (int i = 0; i < 4; i++) tick(r);
    rd(2'd1, v); chk("R2 disabled holds", v, 2);
    wr(2'd1, 32'hA602); wr(2'd1, 32'hB480);
    rd(2'd1, v); chk("R4 refresh ignored when disabled", v, 2);

    // R10 permanent lock
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
    wr(2'd0, 32'h2080);
    rd(2'd0, v); chk("R10 ctrl with permit cleared", v, 32'h2480);
    wr(2'd1, 32'hD928C520);
    rd(2'd0, v); chk("R10 unlock refused", v[11], 0);
    wr(2'd2, 7);
    rd(2'd2, v); chk("R10 timeout stays", v, 100);

    // R1 after a second reset
    doReset();
    rd(2'd0, v); chk("R1 ctrl after reset", v, 32'h08A0);
    rd(2'd2, v); chk("R1 timeout after reset", v, 32'hFFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule